// File: doc/BRIEF.md
# Oversampled Manchester Receive Decoder

This block turns a Manchester-coded serial stream, sampled eight times per bit cell by a fast local clock, into a carrier-present flag, a recovered NRZ data bit and a matching receive clock for a MAC-side controller. A digital edge tracker replaces the analog phase-locked loop. Each accepted mid-cell transition realigns the tracker, and transitions that arrive too soon after one are taken as cell-boundary transitions and skipped. A short glitch filter in front of the tracker replaces the analog squelch, so narrow noise spikes cannot start a frame.

A loopback select swaps the line input for the local encoder's output stream, which makes an on-chip self test possible. Frames are expected to start from an idle-low line with a 1 bit, as an alternating preamble does. The first two recovered bits are used to acquire lock and are not delivered. When mid-cell transitions stop, carrier drops. The receive clock then runs for a fixed number of extra bit periods so the controller can finish its pipeline, and after that it parks low.

Top module: `manch_rx_decoder`

## Requirements
- R1: With `loop_en` = 1 the decoder uses `loop_in` and `line_in` has no effect. With `loop_en` = 0 it uses `line_in`.
- R2: A level on the selected input reaches the decoder only after it has been present for 2 consecutive samples, so a 1-sample pulse never starts carrier or clocks `rxc`.
- R3: From idle, any filtered transition is taken as a start. `crs` rises only on the third accepted mid-cell transition (start plus two more), so a burst that has only two accepted transitions leaves `crs` low.
- R4: A transition fewer than 6 samples after the last accepted mid-cell transition is a cell boundary and is ignored. A transition 6 to 12 samples after it is a mid-cell transition, and the recovered bit is the line level after that transition (high = 1).
- R5: `crs` rises no more than 48 samples (6 bit cells) after the first sample of a frame.
- R6: If no mid-cell transition is accepted within 12 samples of the last one, carrier ends. For an unjittered final transition, `crs` is observed low 15 sample clocks after the clock that presents that transition at the input.
- R7: `rxd` changes only in a sample where `rxc` is low. Each new bit is presented together with a falling `rxc`, and the controller samples it on the next rising `rxc`.
- R8: While `crs` is high, `rxc` has a period of 8 samples (4 high, 4 low) and is reset to its low phase at every accepted mid-cell transition.
- R9: After `crs` falls, `rxc` produces exactly 5 more rising edges, 8 samples apart, and then stays low.
- R10: With no carrier and the post-frame run finished, `rxc` is held low.
- R11: Mid-cell transitions displaced by up to one sample (12.5 ns at 80 MHz) from nominal still decode with no bit errors.
- R12: During reset `crs`, `rxd` and `rxc` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, 8 per bit cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Manchester line input |
| loop_en | input | 1 | Selects the loopback stream instead of the line |
| loop_in | input | 1 | Manchester stream from the local encoder |
| crs | output | 1 | Carrier sense |
| rxd | output | 1 | Recovered NRZ data |
| rxc | output | 1 | Recovered receive clock |

## Verification
The bench drives pulses only one sample wide, a three-sample pulse and a burst with exactly two accepted transitions. A decoder that squelched too loosely, or locked one transition early, would raise `crs` on these. Frames whose mid-cell edges move by one sample in either direction check the 6-sample boundary split. A design that put the split in the wrong place would slip by half a cell and return inverted or missing bits. The bench measures the exact clock on which carrier falls and counts the trailing `rxc` edges, which catches an off-by-one end-of-frame window or a post-frame run that stops too soon or never stops. A frame placed on the line while loopback is selected, and a loopback frame with noise on the line, show whether the input multiplexer is wired the wrong way round.

// File: rtl/manch_rx_pkg.sv
package manch_rx_pkg;

    // Receive link state: nothing seen, acquiring, carrier present
    typedef enum logic [1:0] {
        LN_IDLE = 2'd0,
        LN_HUNT = 2'd1,
        LN_LOCK = 2'd2
    } link_st_e;

    // Default sample ratio and lock / tail sizes
    localparam int unsigned DEF_OSR        = 8;
    localparam int unsigned DEF_FILT_LEN   = 2;
    localparam int unsigned DEF_LOCK_CELLS = 2;
    localparam int unsigned DEF_TAIL_BITS  = 5;

endpackage

// File: rtl/manch_rx_infilt.sv
module manch_rx_infilt #(
    parameter int unsigned FILT_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic loop_en,
    input  logic loop_in,
    output logic lvl_o,
    output logic edge_o
);

    typedef struct packed {
        logic [FILT_LEN-1:0] sh;   // newest sample in bit 0
        logic                f;    // filtered level
        logic                p;    // filtered level one sample ago
    } filt_s;

    filt_s r_d, r_q;
    logic  sel_w;

    assign sel_w = loop_en ? loop_in : line_in;

    always_comb begin
        r_d    = r_q;
        r_d.sh = {r_q.sh[FILT_LEN-2:0], sel_w};
        if (r_q.sh == '0) begin
            r_d.f = 1'b0;
        end else if (r_q.sh == '1) begin
            r_d.f = 1'b1;
        end
        r_d.p = r_q.f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign lvl_o  = r_q.f;
    assign edge_o = r_q.f ^ r_q.p;

    generate
        if (FILT_LEN == 2) begin : g_chk2
            // R2
            glitch_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(r_q.f) |-> ($past(sel_w, 2) == r_q.f) && ($past(sel_w, 3) == r_q.f));
        end
    endgenerate

endmodule

// File: rtl/manch_rx_slicer.sv
module manch_rx_slicer
    import manch_rx_pkg::*;
#(
    parameter int unsigned OSR        = 8,
    parameter int unsigned LOCK_CELLS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic edge_i,
    output logic mid_o,
    output logic eof_o,
    output logic lock_nx_o,
    output logic crs_o,
    output logic rxd_o
);

    localparam int unsigned BND_LIM = (OSR * 3) / 4;
    localparam int unsigned EOF_LIM = (OSR * 3) / 2;
    localparam int unsigned CW      = $clog2(EOF_LIM + 1);
    localparam int unsigned NW      = $clog2(LOCK_CELLS + 1);
    localparam logic [CW-1:0] BND_C = CW'(BND_LIM);
    localparam logic [CW-1:0] EOF_C = CW'(EOF_LIM);
    localparam logic [CW-1:0] ONE_C = CW'(1);
    localparam logic [NW-1:0] LCK_C = NW'(LOCK_CELLS);
    localparam logic [NW-1:0] N1_C  = NW'(1);

    typedef struct packed {
        link_st_e        st;
        logic [CW-1:0]   cnt;    // samples since last accepted mid edge
        logic [NW-1:0]   cells;  // accepted mid edges while acquiring
        logic            rxd;
    } slc_s;

    slc_s s_d, s_q;
    logic accept_w;
    logic mid_w;
    logic eof_w;

    assign accept_w = edge_i && (s_q.cnt >= BND_C);

    always_comb begin
        s_d   = s_q;
        mid_w = 1'b0;
        eof_w = 1'b0;
        unique case (s_q.st)
            LN_IDLE: begin
                if (edge_i) begin
                    s_d.st    = LN_HUNT;
                    s_d.cells = N1_C;
                    mid_w     = 1'b1;
                end
            end
            LN_HUNT: begin
                if (accept_w) begin
                    mid_w = 1'b1;
                    if (s_q.cells == LCK_C) begin
                        s_d.st  = LN_LOCK;
                        s_d.rxd = lvl_i;
                    end else begin
                        s_d.cells = s_q.cells + N1_C;
                    end
                end else if (s_q.cnt >= EOF_C) begin
                    s_d.st = LN_IDLE;
                end
            end
            LN_LOCK: begin
                if (accept_w) begin
                    mid_w   = 1'b1;
                    s_d.rxd = lvl_i;
                end else if (s_q.cnt >= EOF_C) begin
                    s_d.st = LN_IDLE;
                    eof_w  = 1'b1;
                end
            end
            default: begin
                s_d.st = LN_IDLE;
            end
        endcase

        if (mid_w) begin
            s_d.cnt = ONE_C;
        end else if (s_q.cnt < EOF_C) begin
            s_d.cnt = s_q.cnt + ONE_C;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: LN_IDLE, cnt: '0, cells: '0, rxd: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mid_o     = mid_w;
    assign eof_o     = eof_w;
    assign lock_nx_o = (s_d.st == LN_LOCK);
    assign crs_o     = (s_q.st == LN_LOCK);
    assign rxd_o     = s_q.rxd;

    // R3
    lock_from_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crs_o) |-> ($past(s_q.st) == LN_HUNT));

    // R4
    boundary_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crs_o && edge_i && (s_q.cnt < BND_C)) |=> $stable(rxd_o));

    // R6
    window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crs_o |-> (s_q.cnt <= EOF_C));

endmodule

// File: rtl/manch_rx_clkout.sv
module manch_rx_clkout #(
    parameter int unsigned OSR       = 8,
    parameter int unsigned TAIL_BITS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mid_i,
    input  logic eof_i,
    input  logic lock_nx_i,
    input  logic crs_i,
    output logic rxc_o
);

    localparam int unsigned HALF     = OSR / 2;
    localparam int unsigned TAIL_LEN = TAIL_BITS * OSR;
    localparam int unsigned PW       = $clog2(OSR);
    localparam int unsigned TW       = $clog2(TAIL_LEN + 1);
    localparam logic [PW-1:0] PH_TOP  = PW'(OSR - 1);
    localparam logic [PW-1:0] PH_HALF = PW'(HALF);
    localparam logic [PW-1:0] PH_ONE  = PW'(1);
    localparam logic [TW-1:0] TL_LEN  = TW'(TAIL_LEN);
    localparam logic [TW-1:0] TL_ONE  = TW'(1);

    typedef struct packed {
        logic [PW-1:0] ph;    // sample phase inside the recovered cell
        logic [TW-1:0] tail;  // samples left in the post-frame run
        logic          rxc;
    } ck_s;

    ck_s  c_d, c_q;
    logic run_w;

    always_comb begin
        c_d = c_q;
        if (mid_i) begin
            c_d.ph = '0;
        end else if (c_q.ph == PH_TOP) begin
            c_d.ph = '0;
        end else begin
            c_d.ph = c_q.ph + PH_ONE;
        end

        if (eof_i) begin
            c_d.tail = TL_LEN;
        end else if (c_q.tail != '0) begin
            c_d.tail = c_q.tail - TL_ONE;
        end

        run_w   = lock_nx_i || (c_d.tail != '0);
        c_d.rxc = run_w && (c_d.ph >= PH_HALF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rxc_o = c_q.rxc;

    // R10
    parked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!crs_i && (c_q.tail == '0)) |-> !rxc_o);

    // R9
    tail_after_crs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.tail != '0) |-> !crs_i);

endmodule

// File: rtl/manch_rx_decoder.sv
module manch_rx_decoder
    import manch_rx_pkg::*;
#(
    parameter int unsigned OSR        = DEF_OSR,
    parameter int unsigned FILT_LEN   = DEF_FILT_LEN,
    parameter int unsigned LOCK_CELLS = DEF_LOCK_CELLS,
    parameter int unsigned TAIL_BITS  = DEF_TAIL_BITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic loop_en,
    input  logic loop_in,
    output logic crs,
    output logic rxd,
    output logic rxc
);

    logic lvl_w;
    logic edge_w;
    logic mid_w;
    logic eof_w;
    logic lock_nx_w;

    manch_rx_infilt #(
        .FILT_LEN (FILT_LEN)
    ) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .loop_en (loop_en),
        .loop_in (loop_in),
        .lvl_o   (lvl_w),
        .edge_o  (edge_w)
    );

    manch_rx_slicer #(
        .OSR        (OSR),
        .LOCK_CELLS (LOCK_CELLS)
    ) u_slice (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (lvl_w),
        .edge_i    (edge_w),
        .mid_o     (mid_w),
        .eof_o     (eof_w),
        .lock_nx_o (lock_nx_w),
        .crs_o     (crs),
        .rxd_o     (rxd)
    );

    manch_rx_clkout #(
        .OSR       (OSR),
        .TAIL_BITS (TAIL_BITS)
    ) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .mid_i     (mid_w),
        .eof_i     (eof_w),
        .lock_nx_i (lock_nx_w),
        .crs_i     (crs),
        .rxc_o     (rxc)
    );

    // R7
    data_on_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rxd) |-> !rxc);

endmodule

// File: tb/tb_manch_rx_decoder.sv
module tb_manch_rx_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_in = 1'b0;
    logic loop_en = 1'b0;
    logic loop_in = 1'b0;
    logic crs, rxd, rxc;

    manch_rx_decoder dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .loop_en(loop_en),
        .loop_in(loop_in), .crs(crs), .rxd(rxd), .rxc(rxc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    int tick = 0;
    int cyc = 0;
    bit done = 0;

    // behavioural reference state
    logic m_s1 = 0, m_s2 = 0, m_f = 0, m_fp = 0;
    int   m_mode = 0;   // 0 idle, 1 acquiring, 2 carrier
    int   m_since = 0;
    int   m_cells = 0;
    int   m_ph = 0;
    int   m_tail = 0;
    logic m_rxc = 0, m_rxd = 0;

    // observers
    logic prev_rxc = 0, prev_crs = 0, prev_rxd = 0;
    int   rise_tick, fall_tick, post_rises;
    bit   saw_crs, saw_rxc;
    bit   got[$];
    int unsigned lf = 32'h1234_5678;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_step(input logic s);
        bit ed, mid, eofl;
        ed = (m_f != m_fp);
        mid = 0;
        eofl = 0;
        if (m_mode == 0) begin
            if (ed) begin m_mode = 1; m_cells = 1; mid = 1; end
        end else if (ed && m_since >= 6) begin
            mid = 1;
            if (m_mode == 2) m_rxd = m_f;
            else if (m_cells == 2) begin m_mode = 2; m_rxd = m_f; end
            else m_cells++;
        end else if (m_since >= 12) begin
            if (m_mode == 2) eofl = 1;
            m_mode = 0;
        end
        m_since = mid ? 1 : ((m_since >= 12) ? 12 : m_since + 1);
        m_ph    = mid ? 0 : (m_ph + 1) % 8;
        m_tail  = eofl ? 40 : ((m_tail > 0) ? m_tail - 1 : 0);
        m_rxc   = ((m_mode == 2) || (m_tail > 0)) && (m_ph >= 4);
        m_fp = m_f;
        if (m_s1 == m_s2) m_f = m_s1;
        m_s2 = m_s1;
        m_s1 = s;
    endtask

    task automatic step(input logic ln, input logic le, input logic li);
        line_in = ln;
        loop_en = le;
        loop_in = li;
        @(posedge clk);
        tick++;
        model_step(le ? li : ln);
        @(negedge clk);
        chk(crs === (m_mode == 2) && rxd === m_rxd && rxc === m_rxc,
            "R4 R6 R8 cycle model", int'({crs, rxd, rxc}),
            int'({(m_mode == 2), m_rxd, m_rxc}));
        if (crs && !prev_crs) rise_tick = tick;
        if (!crs && prev_crs) fall_tick = tick;
        if (crs) saw_crs = 1;
        if (rxc) saw_rxc = 1;
        if (rxc && !prev_rxc) begin
            if (crs) got.push_back(rxd);
            else post_rises++;
        end
        if (rxd !== prev_rxd) chk(rxc === 1'b0, "R7 rxd moves with rxc low", int'(rxc), 0);
        prev_rxc = rxc;
        prev_crs = crs;
        prev_rxd = rxd;
    endtask

    task automatic clear_obs();
        got.delete();
        post_rises = 0;
        rise_tick = -1;
        fall_tick = -1;
        saw_crs = 0;
        saw_rxc = 0;
    endtask

    // mode 0: frame on line; 1: frame on loop_in, noise on line; 2: frame on line, loopback selected
    task automatic send_frame(input bit bits[$], input int mode, input bit jit,
                              output int t0, output int lastmid);
        logic lv, nz;
        int   d;
        clear_obs();
        t0 = tick + 1;
        lastmid = -1;
        for (int i = 0; i < bits.size(); i++) begin
            for (int s = 0; s < 8; s++) begin
                d  = jit ? (i % 3) - 1 : 0;
                lv = (s < 4) ? ~bits[i] : bits[i];
                if (d == 1 && s == 4) lv = ~bits[i];
                if (d == -1 && s == 3) lv = bits[i];
                if (i == bits.size() - 1 && s == 4 + d) lastmid = tick + 1;
                lf = lf * 32'd1103515245 + 32'd12345;
                nz = lf[16];
                case (mode)
                    0: step(lv, 1'b0, 1'b0);
                    1: step(nz, 1'b1, lv);
                    default: step(lv, 1'b1, 1'b0);
                endcase
            end
        end
        for (int g = 0; g < 90; g++) step(1'b0, (mode != 0), 1'b0);
    endtask

    task automatic verify_frame(input bit bits[$], input int t0, input int lastmid,
                                input string req, input bit end_chk);
        int miss;
        miss = 0;
        chk(got.size() == bits.size() - 2, {req, " bit count"}, got.size(), bits.size() - 2);
        for (int i = 0; i < got.size() && i + 2 < bits.size(); i++)
            if (got[i] != bits[i + 2]) miss++;
        chk(miss == 0, {req, " data bits"}, miss, 0);
        chk(rise_tick >= 0 && rise_tick - t0 <= 48, "R5 carrier within 6 bits", rise_tick - t0, 48);
        if (end_chk)
            chk(fall_tick - lastmid == 15, "R6 end of frame timing", fall_tick - lastmid, 15);
        chk(post_rises == 5, "R9 trailing rxc edges", post_rises, 5);
        chk(rxc === 1'b0 && crs === 1'b0, "R10 rxc parked low", int'({crs, rxc}), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit fa[$], fb[$];
        int t0, lm;
        fa = '{1,0,1,0,1,0,1,1, 0,1,1,0,0,1,0,1, 1,1,0,0};
        fb = '{1,0,1,0,1,0,1,1, 1,1,1,0,1,0,0,0, 1,0,1,1};

        repeat (4) @(negedge clk);
        chk(crs === 1'b0 && rxd === 1'b0 && rxc === 1'b0, "R12 reset outputs",
            int'({crs, rxd, rxc}), 0);
        rst_n = 1'b1;
        for (int g = 0; g < 20; g++) step(1'b0, 1'b0, 1'b0);

        // plain frame ending in 0
        send_frame(fa, 0, 1'b0, t0, lm);
        verify_frame(fa, t0, lm, "R4", 1'b1);

        // jittered frame ending in 1
        send_frame(fb, 0, 1'b1, t0, lm);
        verify_frame(fb, t0, lm, "R11 jitter", 1'b0);

        // one-sample spikes
        clear_obs();
        for (int k = 0; k < 15; k++) begin
            step(1'b1, 1'b0, 1'b0);
            repeat (4) step(1'b0, 1'b0, 1'b0);
        end
        for (int g = 0; g < 20; g++) step(1'b0, 1'b0, 1'b0);
        chk(!saw_crs && !saw_rxc, "R2 spikes ignored", int'({saw_crs, saw_rxc}), 0);

        // three-sample pulse: passes filter, one start edge, boundary edge, then timeout
        clear_obs();
        repeat (3) step(1'b1, 1'b0, 1'b0);
        for (int g = 0; g < 30; g++) step(1'b0, 1'b0, 1'b0);
        chk(!saw_crs && !saw_rxc, "R3 short pulse no carrier", int'({saw_crs, saw_rxc}), 0);

        // eight-sample pulse: exactly two accepted transitions
        clear_obs();
        repeat (8) step(1'b1, 1'b0, 1'b0);
        for (int g = 0; g < 30; g++) step(1'b0, 1'b0, 1'b0);
        chk(!saw_crs && !saw_rxc, "R3 two transitions no carrier", int'({saw_crs, saw_rxc}), 0);

        // loopback frame with noise on the line
        send_frame(fa, 1, 1'b0, t0, lm);
        verify_frame(fa, t0, lm, "R1 loopback", 1'b1);

        // frame on the line while loopback selected
        send_frame(fb, 2, 1'b0, t0, lm);
        chk(!saw_crs && !saw_rxc && got.size() == 0, "R1 line ignored in loopback",
            int'({saw_crs, saw_rxc}), 0);

        // back to the line input
        for (int g = 0; g < 10; g++) step(1'b0, 1'b0, 1'b0);
        send_frame(fb, 0, 1'b0, t0, lm);
        verify_frame(fb, t0, lm, "R1 line path", 1'b1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule